// File: doc/BRIEF.md
# UART Host Register Decoder

This block is the processor-facing register front end of a single serial channel. A host reaches eight address locations through a 3-bit address, an active-low select and separate read and write strobes. The block holds the channel's configuration bytes: interrupt enable, FIFO control, line control, modem control, scratch and the two divisor bytes, plus an alternate-function byte. It returns the receive byte, interrupt status, line status and modem status from the neighbouring logic on reads.

The meaning of an address depends on the direction of the access and on bit 7 of the line control byte, the bank bit. While that bit is set, the three lowest locations reach the divisor pair and the alternate-function byte instead of the data, enable and status/FIFO-control locations. The upper five locations stay in the general set, so software can always clear the bank bit again. Writes to the transmit location and to the FIFO-control location raise one-cycle load pulses for the transmitter and the FIFOs. Reads of the receive and interrupt-status locations raise one-cycle strobes so that those blocks can pop or clear state.

All outputs are registered. Read data, strobes and register updates appear in the cycle after the edge that samples the access.

Top module: `uart_host_regs`

## Requirements
- R1: A synchronous reset clears the interrupt-enable, FIFO-control, line-control, modem-control, scratch and alternate-function bytes to 0x00. It sets the divisor to 0x0001, which is low byte 0x01 and high byte 0x00. It also drives rdata, thr_data and every pulse output to 0.
- R2: With the bank bit (lcr_q[7]) clear, a read returns the following in the next cycle: rhr_data at address 0, the enable byte at 1, isr_data at 2, the line-control byte at 3, the modem-control byte at 4, lsr_data at 5, msr_data at 6 and the scratch byte at 7.
- R3: With the bank bit clear, a write at address 1, 2, 3, 4 or 7 loads wdata into the enable, FIFO-control, line-control, modem-control or scratch byte respectively. The new value is visible in the next cycle.
- R4: Writes to address 5 or 6 change no register and raise no pulse.
- R5: With the bank bit set, addresses 0, 1 and 2 read and write the divisor low byte, the divisor high byte and the alternate-function byte. They raise no load or read strobe.
- R6: With the bank bit set, addresses 3 to 7 behave as in R2 and R3.
- R7: A write at address 0 with the bank bit clear gives thr_load high for exactly the next cycle, with thr_data equal to the written byte. thr_data holds its value otherwise.
- R8: A write at address 2 with the bank bit clear gives fcr_load high for exactly the next cycle.
- R9: A read at address 0 with the bank bit clear gives rhr_rd_stb high for the next cycle. A read at address 2 with the bank bit clear gives isr_rd_stb high for the next cycle.
- R10: While cs_n is high, strobes have no effect: no register changes, no pulse is raised, and rdata is 0 in the next cycle. rdata is also 0 after any cycle without a read.
- R11: A read and a write in the same cycle both use the bank bit and register values from before the write. The read returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select |
| addr | input | 3 | Register location |
| rd_en | input | 1 | Read strobe, sampled each edge |
| wr_en | input | 1 | Write strobe, sampled each edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rhr_data | input | 8 | Receive byte source |
| isr_data | input | 8 | Interrupt status source |
| lsr_data | input | 8 | Line status source |
| msr_data | input | 8 | Modem status source |
| thr_data | output | 8 | Last byte written to the transmit location |
| thr_load | output | 1 | One-cycle transmit load pulse |
| fcr_load | output | 1 | One-cycle FIFO-control write pulse |
| rhr_rd_stb | output | 1 | One-cycle receive-read strobe |
| isr_rd_stb | output | 1 | One-cycle status-read strobe |
| ier_q | output | 8 | Interrupt enable byte |
| fcr_q | output | 8 | FIFO control byte |
| lcr_q | output | 8 | Line control byte, bit 7 is the bank bit |
| mcr_q | output | 8 | Modem control byte |
| dll_q | output | 8 | Divisor low byte |
| dlm_q | output | 8 | Divisor high byte |
| afr_q | output | 8 | Alternate-function byte |

## Verification
The hardest case to reach is an access to the three low locations while the bank bit is set, combined with a simultaneous line-control write. Only an earlier write to address 3 with bit 7 high can set up that condition. The stimulus biases random writes toward address 3 with bit 7 set about half the time, so the bank bit flips often. It also mixes reads and writes in the same cycle, and directed sequences enter and leave the bank explicitly before the random phase.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
  // Register locations within the 8-entry window
  localparam int ADR_DATA = 0;
  localparam int ADR_IER  = 1;
  localparam int ADR_STAT = 2;
  localparam int ADR_LCR  = 3;
  localparam int ADR_MCR  = 4;
  localparam int ADR_LSR  = 5;
  localparam int ADR_MSR  = 6;
  localparam int ADR_SPR  = 7;

  // Storage slots for the held bytes
  localparam int IDX_IER = 0;
  localparam int IDX_FCR = 1;
  localparam int IDX_LCR = 2;
  localparam int IDX_MCR = 3;
  localparam int IDX_SPR = 4;
  localparam int IDX_DLL = 5;
  localparam int IDX_DLM = 6;
  localparam int IDX_AFR = 7;
  localparam int NREG    = 8;

  localparam int BANK_BIT = 7;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_RHR, SEL_IER, SEL_ISR, SEL_LCR, SEL_MCR,
    SEL_LSR, SEL_MSR, SEL_SPR, SEL_DLL, SEL_DLM, SEL_AFR
  } rd_sel_e;
endpackage

// File: rtl/uart_reg_decode.sv
module uart_reg_decode
  import uart_regs_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              cs_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic              bank,
  output rd_sel_e           rd_sel,
  output logic [NREG-1:0]   reg_we,
  output logic              thr_we
);
  always_comb begin
    rd_sel = SEL_NONE;
    if (!cs_n && rd_en) begin
      case (addr)
        ADDR_W'(ADR_DATA): rd_sel = bank ? SEL_DLL : SEL_RHR;
        ADDR_W'(ADR_IER):  rd_sel = bank ? SEL_DLM : SEL_IER;
        ADDR_W'(ADR_STAT): rd_sel = bank ? SEL_AFR : SEL_ISR;
        ADDR_W'(ADR_LCR):  rd_sel = SEL_LCR;
        ADDR_W'(ADR_MCR):  rd_sel = SEL_MCR;
        ADDR_W'(ADR_LSR):  rd_sel = SEL_LSR;
        ADDR_W'(ADR_MSR):  rd_sel = SEL_MSR;
        ADDR_W'(ADR_SPR):  rd_sel = SEL_SPR;
        default:           rd_sel = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    reg_we = '0;
    thr_we = 1'b0;
    if (!cs_n && wr_en) begin
      case (addr)
        ADDR_W'(ADR_DATA): if (bank) reg_we[IDX_DLL] = 1'b1; else thr_we = 1'b1;
        ADDR_W'(ADR_IER):  if (bank) reg_we[IDX_DLM] = 1'b1; else reg_we[IDX_IER] = 1'b1;
        ADDR_W'(ADR_STAT): if (bank) reg_we[IDX_AFR] = 1'b1; else reg_we[IDX_FCR] = 1'b1;
        ADDR_W'(ADR_LCR):  reg_we[IDX_LCR] = 1'b1;
        ADDR_W'(ADR_MCR):  reg_we[IDX_MCR] = 1'b1;
        ADDR_W'(ADR_SPR):  reg_we[IDX_SPR] = 1'b1;
        default:           reg_we = '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_reg_store.sv
module uart_reg_store
  import uart_regs_pkg::*;
#(
  parameter int                  DATA_W    = 8,
  parameter logic [2*DATA_W-1:0] DIV_RESET = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NREG-1:0]       reg_we,
  input  logic                  thr_we,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     regs_q [NREG],
  output logic [DATA_W-1:0]     thr_data,
  output logic                  thr_load,
  output logic                  fcr_load
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [DATA_W-1:0] RST_VAL =
      (i == IDX_DLL) ? DIV_RESET[DATA_W-1:0] :
      (i == IDX_DLM) ? DIV_RESET[2*DATA_W-1:DATA_W] : '0;
    always_ff @(posedge clk) begin
      if (rst)            regs_q[i] <= RST_VAL;
      else if (reg_we[i]) regs_q[i] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_data <= '0;
      thr_load <= 1'b0;
      fcr_load <= 1'b0;
    end else begin
      thr_load <= thr_we;
      fcr_load <= reg_we[IDX_FCR];
      if (thr_we) thr_data <= wdata;
    end
  end

  // R7
  thr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(thr_we) |-> $stable(thr_data));
endmodule

// File: rtl/uart_read_path.sv
module uart_read_path
  import uart_regs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  rd_sel_e           rd_sel,
  input  logic [DATA_W-1:0] regs_q [NREG],
  input  logic [DATA_W-1:0] rhr_data,
  input  logic [DATA_W-1:0] isr_data,
  input  logic [DATA_W-1:0] lsr_data,
  input  logic [DATA_W-1:0] msr_data,
  output logic [DATA_W-1:0] rdata,
  output logic              rhr_rd_stb,
  output logic              isr_rd_stb
);
  logic [DATA_W-1:0] mux_d;

  always_comb begin
    case (rd_sel)
      SEL_RHR: mux_d = rhr_data;
      SEL_IER: mux_d = regs_q[IDX_IER];
      SEL_ISR: mux_d = isr_data;
      SEL_LCR: mux_d = regs_q[IDX_LCR];
      SEL_MCR: mux_d = regs_q[IDX_MCR];
      SEL_LSR: mux_d = lsr_data;
      SEL_MSR: mux_d = msr_data;
      SEL_SPR: mux_d = regs_q[IDX_SPR];
      SEL_DLL: mux_d = regs_q[IDX_DLL];
      SEL_DLM: mux_d = regs_q[IDX_DLM];
      SEL_AFR: mux_d = regs_q[IDX_AFR];
      default: mux_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata      <= '0;
      rhr_rd_stb <= 1'b0;
      isr_rd_stb <= 1'b0;
    end else begin
      rdata      <= mux_d;
      rhr_rd_stb <= (rd_sel == SEL_RHR);
      isr_rd_stb <= (rd_sel == SEL_ISR);
    end
  end

  // R9
  stb_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(rhr_rd_stb && isr_rd_stb));
endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
  import uart_regs_pkg::*;
#(
  parameter int                  ADDR_W    = 3,
  parameter int                  DATA_W    = 8,
  parameter logic [2*DATA_W-1:0] DIV_RESET = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] rhr_data,
  input  logic [DATA_W-1:0] isr_data,
  input  logic [DATA_W-1:0] lsr_data,
  input  logic [DATA_W-1:0] msr_data,
  output logic [DATA_W-1:0] thr_data,
  output logic              thr_load,
  output logic              fcr_load,
  output logic              rhr_rd_stb,
  output logic              isr_rd_stb,
  output logic [DATA_W-1:0] ier_q,
  output logic [DATA_W-1:0] fcr_q,
  output logic [DATA_W-1:0] lcr_q,
  output logic [DATA_W-1:0] mcr_q,
  output logic [DATA_W-1:0] dll_q,
  output logic [DATA_W-1:0] dlm_q,
  output logic [DATA_W-1:0] afr_q
);
  rd_sel_e           rd_sel;
  logic [NREG-1:0]   reg_we;
  logic              thr_we;
  logic [DATA_W-1:0] regs_q [NREG];
  logic              bank;

  assign bank = regs_q[IDX_LCR][BANK_BIT];

  uart_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .cs_n(cs_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en), .bank(bank),
    .rd_sel(rd_sel), .reg_we(reg_we), .thr_we(thr_we)
  );

  uart_reg_store #(.DATA_W(DATA_W), .DIV_RESET(DIV_RESET)) u_store (
    .clk(clk), .rst(rst), .reg_we(reg_we), .thr_we(thr_we), .wdata(wdata),
    .regs_q(regs_q), .thr_data(thr_data), .thr_load(thr_load), .fcr_load(fcr_load)
  );

  uart_read_path #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .rd_sel(rd_sel), .regs_q(regs_q),
    .rhr_data(rhr_data), .isr_data(isr_data), .lsr_data(lsr_data), .msr_data(msr_data),
    .rdata(rdata), .rhr_rd_stb(rhr_rd_stb), .isr_rd_stb(isr_rd_stb)
  );

  assign ier_q = regs_q[IDX_IER];
  assign fcr_q = regs_q[IDX_FCR];
  assign lcr_q = regs_q[IDX_LCR];
  assign mcr_q = regs_q[IDX_MCR];
  assign dll_q = regs_q[IDX_DLL];
  assign dlm_q = regs_q[IDX_DLM];
  assign afr_q = regs_q[IDX_AFR];

  // R1
  reset_div_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dll_q == DIV_RESET[DATA_W-1:0] && dlm_q == DIV_RESET[2*DATA_W-1:DATA_W]
                    && lcr_q == '0 && ier_q == '0));

  // R7
  thr_source_chk: assert property (@(posedge clk) disable iff (rst)
    thr_load |-> $past(!cs_n && wr_en && addr == ADDR_W'(ADR_DATA) && !lcr_q[BANK_BIT]));

  // R10
  idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (rdata == '0 && !thr_load && !fcr_load && !rhr_rd_stb && !isr_rd_stb));

  // R4
  ro_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && wr_en && (addr == ADDR_W'(ADR_LSR) || addr == ADDR_W'(ADR_MSR)))
      |=> ($stable(lcr_q) && $stable(ier_q) && $stable(fcr_q) && $stable(mcr_q)
           && $stable(dll_q) && $stable(dlm_q) && $stable(afr_q) && !thr_load && !fcr_load));

  // R5
  banked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && lcr_q[BANK_BIT] && addr < ADDR_W'(3))
      |=> (!thr_load && !fcr_load && !rhr_rd_stb && !isr_rd_stb));
endmodule

// File: tb/sim_uart_host_regs.sv
module sim_uart_host_regs;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1;
  logic [2:0] addr = '0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wdata = '0, rhr_data = '0, isr_data = '0, lsr_data = '0, msr_data = '0;
  logic [7:0] rdata, thr_data, ier_q, fcr_q, lcr_q, mcr_q, dll_q, dlm_q, afr_q;
  logic       thr_load, fcr_load, rhr_rd_stb, isr_rd_stb;

  int n_chk = 0, n_bad = 0, cyc = 0;

  // bench model of the held bytes
  logic [7:0] m_ier, m_fcr, m_lcr, m_mcr, m_spr, m_dll, m_dlm, m_afr, m_thr;
  logic [7:0] e_rdata;
  logic       e_thr, e_fcr, e_rhr, e_isr;
  string      t_rd, t_wr;

  always #10 clk = ~clk;

  uart_host_regs u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .rhr_data(rhr_data), .isr_data(isr_data),
    .lsr_data(lsr_data), .msr_data(msr_data), .thr_data(thr_data), .thr_load(thr_load),
    .fcr_load(fcr_load), .rhr_rd_stb(rhr_rd_stb), .isr_rd_stb(isr_rd_stb),
    .ier_q(ier_q), .fcr_q(fcr_q), .lcr_q(lcr_q), .mcr_q(mcr_q),
    .dll_q(dll_q), .dlm_q(dlm_q), .afr_q(afr_q)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string what, string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(logic [2:0] a, logic bk);
    case (a)
      3'd0: return bk ? m_dll : rhr_data;
      3'd1: return bk ? m_dlm : m_ier;
      3'd2: return bk ? m_afr : isr_data;
      3'd3: return m_lcr;
      3'd4: return m_mcr;
      3'd5: return lsr_data;
      3'd6: return msr_data;
      default: return m_spr;
    endcase
  endfunction

  task automatic model_reset();
    m_ier = 0; m_fcr = 0; m_lcr = 0; m_mcr = 0; m_spr = 0;
    m_dll = 8'h01; m_dlm = 8'h00; m_afr = 0; m_thr = 0;
    e_rdata = 0; e_thr = 0; e_fcr = 0; e_rhr = 0; e_isr = 0;
    t_rd = "R1"; t_wr = "R1";
  endtask

  task automatic compare_all();
    chk("rdata", t_rd, rdata, e_rdata);
    chk("rhr_rd_stb", (t_rd == "R1") ? "R1" : "R9", {7'd0, rhr_rd_stb}, {7'd0, e_rhr});
    chk("isr_rd_stb", (t_rd == "R1") ? "R1" : "R9", {7'd0, isr_rd_stb}, {7'd0, e_isr});
    chk("thr_load", (t_wr == "R1") ? "R1" : "R7", {7'd0, thr_load}, {7'd0, e_thr});
    chk("fcr_load", (t_wr == "R1") ? "R1" : "R8", {7'd0, fcr_load}, {7'd0, e_fcr});
    chk("thr_data", (t_wr == "R1") ? "R1" : "R7", thr_data, m_thr);
    chk("ier", t_wr, ier_q, m_ier);
    chk("fcr", t_wr, fcr_q, m_fcr);
    chk("lcr", t_wr, lcr_q, m_lcr);
    chk("mcr", t_wr, mcr_q, m_mcr);
    chk("dll", t_wr, dll_q, m_dll);
    chk("dlm", t_wr, dlm_q, m_dlm);
    chk("afr", t_wr, afr_q, m_afr);
  endtask

  // drive one access at a falling edge, predict, then check at the next falling edge
  task automatic step(logic c, logic [2:0] a, logic r, logic w, logic [7:0] d);
    logic bk;
    cs_n = c; addr = a; rd_en = r; wr_en = w; wdata = d;
    rhr_data = 8'($urandom); isr_data = 8'($urandom);
    lsr_data = 8'($urandom); msr_data = 8'($urandom);
    bk = m_lcr[7];
    e_rdata = 0; e_rhr = 0; e_isr = 0; e_thr = 0; e_fcr = 0;
    if (c)              t_rd = "R10";
    else if (r && w)    t_rd = "R11";
    else if (bk && a < 3) t_rd = "R5";
    else if (bk)        t_rd = "R6";
    else                t_rd = r ? "R2" : "R10";
    if (c)                     t_wr = "R10";
    else if (a == 5 || a == 6) t_wr = "R4";
    else if (bk && a < 3)      t_wr = "R5";
    else if (bk)               t_wr = "R6";
    else                       t_wr = "R3";
    if (!c && r) begin
      e_rdata = exp_read(a, bk);
      e_rhr = (a == 0) && !bk;
      e_isr = (a == 2) && !bk;
    end
    if (!c && w) begin
      case (a)
        3'd0: if (bk) m_dll = d; else begin m_thr = d; e_thr = 1; end
        3'd1: if (bk) m_dlm = d; else m_ier = d;
        3'd2: if (bk) m_afr = d; else begin m_fcr = d; e_fcr = 1; end
        3'd3: m_lcr = d;
        3'd4: m_mcr = d;
        3'd7: m_spr = d;
        default: ;
      endcase
    end
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    void'($urandom(32'd20240517));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    compare_all();                         // R1 reset state
    step(0, 3'd7, 0, 1, 8'h5A);            // R3 scratch
    step(0, 3'd7, 1, 0, 8'h00);            // R2 scratch readback
    step(0, 3'd0, 0, 1, 8'hA5);            // R7 transmit load
    step(0, 3'd2, 0, 1, 8'hC1);            // R8 FIFO control
    step(0, 3'd0, 1, 0, 8'h00);            // R9 receive strobe
    step(0, 3'd2, 1, 0, 8'h00);            // R9 status strobe
    step(0, 3'd5, 0, 1, 8'hFF);            // R4
    step(0, 3'd6, 0, 1, 8'hFF);            // R4
    step(0, 3'd3, 0, 1, 8'h83);            // enter bank
    step(0, 3'd0, 0, 1, 8'h34);            // R5 divisor low
    step(0, 3'd1, 0, 1, 8'h12);            // R5 divisor high
    step(0, 3'd2, 1, 1, 8'h07);            // R11 + R5 alternate byte
    step(0, 3'd0, 1, 0, 8'h00);            // R5 read divisor low
    step(0, 3'd4, 0, 1, 8'h1F);            // R6 modem control in bank
    step(1, 3'd3, 1, 1, 8'h00);            // R10 deselected
    step(0, 3'd3, 1, 1, 8'h03);            // R11 leave bank, old LCR read
    step(0, 3'd0, 1, 1, 8'h66);            // R11 both strobes at address 0
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] a;
      logic [7:0] d;
      a = 3'($urandom);
      d = 8'($urandom);
      if (($urandom % 4) == 0) begin a = 3'd3; d[7] = $urandom % 2; end
      step(($urandom % 6) == 0, a, ($urandom % 2) == 1, ($urandom % 2) == 1, d);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule